// File: doc/BRIEF.md
# Execute Stage ALU with Branch Compare

This block is the execute stage of a small scalar integer pipeline. Each cycle it takes a 4-bit operation code from the decoder, two register operands, an immediate value and a flag that picks the immediate in place of the second register operand. From these it computes a data word for the memory and writeback stages and a branch decision for the fetch stage.

It supports three groups of operations. Six are compares, which drive only the branch decision. Addition and three bitwise logic operations fill the data word. Three shifts take their amount from the low bits of the second operand. Both outputs are registered on the rising clock edge, so a result appears one cycle after its inputs. A synchronous active-low reset clears both outputs.

Top module: `exec_stage`

## Requirements
- R1: When `sel_imm` is 1, `imm_val` is the second operand; when it is 0, `rs2_val` is the second operand, for every operation.
- R2: Code 0 (equal) sets `take_branch` when the two operands match. Code 1 (not equal) sets it when they differ.
- R3: Code 2 (signed less-than) and code 3 (signed greater-or-equal) compare the operands as two's-complement values.
- R4: Code 4 (unsigned less-than) and code 5 (unsigned greater-or-equal) compare the operands as unsigned values.
- R5: For the compare codes 0 to 5, `alu_out` is 0.
- R6: Code 6 adds the operands modulo 2^XLEN.
- R7: Code 7 gives the bitwise XOR of the operands, code 8 the bitwise OR, and code 9 the bitwise AND.
- R8: Code 10 shifts left and code 12 shifts right logically, filling with zeros. The shift amount is the low log2(XLEN) bits of the second operand.
- R9: Code 11 shifts right arithmetically, filling the vacated bits with bit XLEN-1 of the first operand. It uses the same shift amount as R8.
- R10: For codes 6 to 12, `take_branch` is 0.
- R11: Codes 13, 14 and 15 give `alu_out` = 0 and `take_branch` = 0.
- R12: While `rst_n` is 0, both outputs are 0 after the next rising edge. Otherwise the outputs take the values for the inputs present at each rising edge.
- R13: XLEN is a parameter (default 32). At XLEN = 64 the add carries across all 64 bits and shifts use a 6-bit amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Operation select, codes 0 to 12 defined |
| rs1_val | input | XLEN | First operand, from register source 1 |
| rs2_val | input | XLEN | Second register operand, from register source 2 |
| imm_val | input | XLEN | Immediate from the decoder |
| sel_imm | input | 1 | 1 selects the immediate as second operand |
| alu_out | output | XLEN | Registered data result for memory and writeback |
| take_branch | output | 1 | Registered branch decision for fetch |

## Verification
The assertions assume that `op_code` and `rst_n` hold known values at every rising edge, and that reset is held low through at least the first edge. The bench drives every input from time zero and changes it only on the falling edge. Because of this, each property sees a complete, stable operation code one edge before it checks the registered outputs. All undefined codes are driven only with known operands, so the checks for a zero result do not depend on the data paths.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [3:0] {
        OP_EQ   = 4'd0,
        OP_NE   = 4'd1,
        OP_LTS  = 4'd2,
        OP_GES  = 4'd3,
        OP_LTU  = 4'd4,
        OP_GEU  = 4'd5,
        OP_ADD  = 4'd6,
        OP_XOR  = 4'd7,
        OP_OR   = 4'd8,
        OP_AND  = 4'd9,
        OP_SHL  = 4'd10,
        OP_SHRA = 4'd11,
        OP_SHRL = 4'd12
    } exec_op_e;

    localparam logic [3:0] LAST_CMP_CODE = 4'd5;
    localparam logic [3:0] LAST_OP_CODE  = 4'd12;

    function automatic logic op_is_compare(input logic [3:0] code);
        return code <= LAST_CMP_CODE;
    endfunction

    function automatic logic op_is_defined(input logic [3:0] code);
        return code <= LAST_OP_CODE;
    endfunction

endpackage

// File: rtl/exec_cmp.sv
module exec_cmp
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            taken
);
    logic same;
    logic below_s;
    logic below_u;

    always_comb begin
        same    = (opa == opb);
        below_u = (opa < opb);
        below_s = ($signed(opa) < $signed(opb));
        case (op_code)
            OP_EQ:   taken = same;
            OP_NE:   taken = !same;
            OP_LTS:  taken = below_s;
            OP_GES:  taken = !below_s;
            OP_LTU:  taken = below_u;
            OP_GEU:  taken = !below_u;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_arith.sv
module exec_arith
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] res
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] amt;

    always_comb begin
        amt = opb[SHW-1:0];
        case (op_code)
            OP_ADD:  res = opa + opb;
            OP_XOR:  res = opa ^ opb;
            OP_OR:   res = opa | opb;
            OP_AND:  res = opa & opb;
            OP_SHL:  res = opa << amt;
            OP_SHRL: res = opa >> amt;
            OP_SHRA: res = XLEN'($signed(opa) >>> amt);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] imm_val,
    input  logic            sel_imm,
    output logic [XLEN-1:0] alu_out,
    output logic            take_branch
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            take;
    } stage_t;

    stage_t          stage_d, stage_q;
    logic [XLEN-1:0] opb_d;
    logic [XLEN-1:0] arith_d;
    logic            cmp_d;

    exec_cmp #(.XLEN(XLEN)) u_cmp (
        .op_code (op_code),
        .opa     (rs1_val),
        .opb     (opb_d),
        .taken   (cmp_d)
    );

    exec_arith #(.XLEN(XLEN)) u_arith (
        .op_code (op_code),
        .opa     (rs1_val),
        .opb     (opb_d),
        .res     (arith_d)
    );

    always_comb begin
        opb_d = sel_imm ? imm_val : rs2_val;
        stage_d = '0;
        if (rst_n && op_is_defined(op_code)) begin
            if (op_is_compare(op_code)) begin
                stage_d.take = cmp_d;
            end else begin
                stage_d.res = arith_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign alu_out     = stage_q.res;
    assign take_branch = stage_q.take;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (alu_out == '0 && !take_branch)); // R12

    AST_CMP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code <= 4'd5) |=> (alu_out == '0)); // R5

    AST_DATA_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd6) |=> !take_branch); // R10

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd13) |=> (alu_out == '0 && !take_branch)); // R11

    AST_EQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 && !sel_imm && rs1_val == rs2_val) |=> take_branch); // R2
endmodule

// File: tb/tb_exec_stage.sv
`timescale 1ns/1ps
module tb_exec_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd6;
    logic [31:0] a = 32'd1, b = 32'd1, im = 32'd0;
    logic        ui = 1'b0;
    logic [31:0] res;
    logic        tk;

    logic [3:0]  op64 = 4'd6;
    logic [63:0] a64 = 64'd0, b64 = 64'd0, im64 = 64'd0;
    logic        ui64 = 1'b0;
    logic [63:0] res64;
    logic        tk64;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    exec_stage #(.XLEN(32)) dut (
        .clk(clk), .rst_n(rst_n), .op_code(op), .rs1_val(a), .rs2_val(b),
        .imm_val(im), .sel_imm(ui), .alu_out(res), .take_branch(tk)
    );

    exec_stage #(.XLEN(64)) dut64 (
        .clk(clk), .rst_n(rst_n), .op_code(op64), .rs1_val(a64), .rs2_val(b64),
        .imm_val(im64), .sel_imm(ui64), .alu_out(res64), .take_branch(tk64)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] im;
        logic        ui;
        logic [31:0] res;
        logic        tk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'd5,        32'd5,        32'd0, 1'b0, 32'd0,        1'b1, 8'd2},  // R2 equal
        '{4'd0,  32'd5,        32'd6,        32'd0, 1'b0, 32'd0,        1'b0, 8'd2},  // R2 not equal
        '{4'd1,  32'd5,        32'd6,        32'd0, 1'b0, 32'd0,        1'b1, 8'd2},  // R2 ne taken
        '{4'd1,  32'd9,        32'd9,        32'd0, 1'b0, 32'd0,        1'b0, 8'd2},  // R2 ne not taken
        '{4'd0,  32'd7,        32'd9,        32'd7, 1'b1, 32'd0,        1'b1, 8'd1},  // R1 imm used
        '{4'd0,  32'd7,        32'd7,        32'd9, 1'b1, 32'd0,        1'b0, 8'd1},  // R1 rs2 ignored
        '{4'd2,  32'hFFFFFFFF, 32'd1,        32'd0, 1'b0, 32'd0,        1'b1, 8'd3},  // R3 -1 < 1
        '{4'd3,  32'hFFFFFFFF, 32'd1,        32'd0, 1'b0, 32'd0,        1'b0, 8'd3},  // R3
        '{4'd3,  32'd3,        32'd3,        32'd0, 1'b0, 32'd0,        1'b1, 8'd3},  // R3 equal ge
        '{4'd4,  32'hFFFFFFFF, 32'd1,        32'd0, 1'b0, 32'd0,        1'b0, 8'd4},  // R4
        '{4'd5,  32'hFFFFFFFF, 32'd1,        32'd0, 1'b0, 32'd0,        1'b1, 8'd4},  // R4
        '{4'd4,  32'd2,        32'd3,        32'd0, 1'b0, 32'd0,        1'b1, 8'd4},  // R4
        '{4'd0,  32'hDEADBEEF, 32'hDEADBEEF, 32'd0, 1'b0, 32'd0,        1'b1, 8'd5},  // R5 data zero
        '{4'd6,  32'hFFFFFFFF, 32'd2,        32'd0, 1'b0, 32'd1,        1'b0, 8'd6},  // R6 wrap
        '{4'd6,  32'd10,       32'd99,       32'd5, 1'b1, 32'd15,       1'b0, 8'd1},  // R1 add imm
        '{4'd6,  32'd4,        32'd4,        32'd0, 1'b0, 32'd8,        1'b0, 8'd10}, // R10 equal operands
        '{4'd7,  32'hF0F0F0F0, 32'hFF00FF00, 32'd0, 1'b0, 32'h0FF00FF0, 1'b0, 8'd7},  // R7 xor
        '{4'd8,  32'hF0F0F0F0, 32'h0000FFFF, 32'd0, 1'b0, 32'hF0F0FFFF, 1'b0, 8'd7},  // R7 or
        '{4'd9,  32'hF0F0F0F0, 32'h0000FFFF, 32'd0, 1'b0, 32'h0000F0F0, 1'b0, 8'd7},  // R7 and
        '{4'd10, 32'd1,        32'h21,       32'd0, 1'b0, 32'd2,        1'b0, 8'd8},  // R8 low bits only
        '{4'd12, 32'h80000000, 32'd31,       32'd0, 1'b0, 32'd1,        1'b0, 8'd8},  // R8 zero fill
        '{4'd11, 32'h80000000, 32'd4,        32'd0, 1'b0, 32'hF8000000, 1'b0, 8'd9},  // R9 sign fill
        '{4'd11, 32'h40000000, 32'd4,        32'd0, 1'b0, 32'h04000000, 1'b0, 8'd9},  // R9 positive
        '{4'd13, 32'd5,        32'd5,        32'd0, 1'b0, 32'd0,        1'b0, 8'd11}  // R11 undefined
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive32(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                           input logic [31:0] z, input logic s);
        @(negedge clk);
        op = o; a = x; b = y; im = z; ui = s;
        @(negedge clk);
    endtask

    task automatic drive64(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
        @(negedge clk);
        op64 = o; a64 = x; b64 = y; im64 = 64'd0; ui64 = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R12: reset state with an add pending
        repeat (3) @(negedge clk);
        chk("R12 reset res", {32'd0, res}, 64'd0);
        chk("R12 reset tk", {63'd0, tk}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive32(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].im, VECS[i].ui);
            chk($sformatf("R%0d vec%0d res", VECS[i].req, i), {32'd0, res}, {32'd0, VECS[i].res});
            chk($sformatf("R%0d vec%0d tk", VECS[i].req, i), {63'd0, tk}, {63'd0, VECS[i].tk});
        end

        // R11: codes 14 and 15 with values that would add to nonzero
        drive32(4'd14, 32'd3, 32'd4, 32'd0, 1'b0);
        chk("R11 code14", {31'd0, tk, res}, 64'd0);
        drive32(4'd15, 32'd1, 32'd1, 32'd0, 1'b0);
        chk("R11 code15", {31'd0, tk, res}, 64'd0);

        // R12: one cycle latency, output holds before the edge
        drive32(4'd6, 32'd20, 32'd22, 32'd0, 1'b0);
        @(negedge clk);
        op = 4'd6; a = 32'd1; b = 32'd1;
        @(posedge clk); #1;
        chk("R12 new value after edge", {32'd0, res}, 64'd2);

        // R12: synchronous reset mid-run
        @(negedge clk);
        op = 4'd0; a = 32'd3; b = 32'd3; rst_n = 1'b0;
        @(negedge clk);
        chk("R12 sync clear", {31'd0, tk, res}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after release", {63'd0, tk}, 64'd1);

        // R13: 64-bit instance
        drive64(4'd6, 64'h00000000FFFFFFFF, 64'd1);
        chk("R13 add carry", res64, 64'h0000000100000000);
        drive64(4'd10, 64'd1, 64'd63);
        chk("R13 shl 63", res64, 64'h8000000000000000);
        drive64(4'd10, 64'd1, 64'h41);
        chk("R13 shamt 6 bits", res64, 64'd2);
        drive64(4'd11, 64'h8000000000000000, 64'd8);
        chk("R13 sra", res64, 64'hFF80000000000000);
        drive64(4'd2, 64'h8000000000000000, 64'd0);
        chk("R13 signed lt", {63'd0, tk64}, 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule